// File: doc/BRIEF.md
# Supply-Low Monitoring Suspend Controller

This block compares each digitized core-supply reading with a programmable low limit and governs a thermal-event duration timer across sleep states. When a fresh reading lands below the limit, a sticky under-limit status bit is set, an alert level is raised if alerts are enabled, and the duration timer is frozen at its current count. The timer is not cleared while frozen. Once a later reading sits at or above the limit, the timer picks up counting again from the frozen value, with no software action.

The duration timer counts a prescaled tick for as long as the active-low thermal input is held low, monitoring is enabled, and the supply is not under its limit. It stops at its maximum value and does not wrap. Monitoring is disabled after reset. Software turns it on through `mon_en`. Until then, supply samples are ignored and the timer stays idle.

The bit is read through a one-cycle read strobe. That read clears the bit only once the supply is back in range.

Top module: `supply_suspend_ctrl`

## Requirements
- R1: While `mon_en` is 1, each cycle with `smp_valid` high compares `smp_data` with `low_limit` as unsigned values. The result is "under" only when `smp_data < low_limit` (equality is not under). Cycles without `smp_valid`, or with `mon_en` low, leave the last result unchanged.
- R2: A comparison that yields "under" sets `under_flag` at the same clock edge that registers the comparison, so it is visible one cycle after the sample is presented.
- R3: `under_flag` is sticky. A `stat_rd` pulse clears it only when the current comparison result is not "under". If a read arrives while the supply is still under the limit, the flag stays set.
- R4: `alert` is 1 exactly when `under_flag` is 1 and `alert_en` is 1. It follows `alert_en` with no added cycle.
- R5: `timer_val` advances by one for every PRESCALE clock cycles in which `therm_n` is 0, `mon_en` is 1 and the registered comparison result is not "under". Qualifying cycles accumulate across gaps, because the prescaler phase is kept.
- R6: While the registered comparison result is "under", `timer_val` and the prescaler phase hold. Counting resumes from the held value after a sample at or above the limit.
- R7: `timer_val` saturates at 2^TIMER_W-1 and never wraps.
- R8: After reset, `under_flag`, `alert` and `timer_val` are 0. While `mon_en` is 0, samples are ignored and the timer does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitoring enable, set by software |
| smp_valid | input | 1 | Marks a new supply reading on `smp_data` |
| smp_data | input | SAMPLE_W | Digitized core-supply reading |
| low_limit | input | SAMPLE_W | Programmable low limit |
| alert_en | input | 1 | Enables the alert output |
| therm_n | input | 1 | Active-low thermal event input (synchronous) |
| stat_rd | input | 1 | One-cycle status read strobe |
| under_flag | output | 1 | Sticky under-limit status bit |
| alert | output | 1 | Alert level |
| timer_val | output | TIMER_W | Thermal-event duration count |

## Verification
The comparator is swept over every pair of sample and limit values in a 4-bit configuration, with a read strobe on each sample. This separates strict from non-strict comparison and shows that the flag tracks each fresh result. The bench then runs sticky sequences, which distinguish a read made while the supply is still under the limit from a read made after it has recovered, and which present a recovered value without `smp_valid` to show that stale data is ignored. Thermal-low stretches that are broken by releases, by an under-limit suspension and by disabled monitoring are checked on every cycle against an accumulated qualifying-cycle count divided by the prescale. This tells a frozen prescaler phase apart from a reset one. A long final stretch reaches saturation.

// File: rtl/sslc_pkg.sv
`timescale 1ns/1ps
package sslc_pkg;

  typedef enum logic [1:0] {
    TM_OFF     = 2'd0,
    TM_SUSPEND = 2'd1,
    TM_IDLE    = 2'd2,
    TM_COUNT   = 2'd3
  } tmr_mode_e;

  // Monitoring disabled dominates, then supply suspension, then thermal input.
  function automatic tmr_mode_e pick_mode(logic mon_en, logic below, logic therm_n);
    if (!mon_en)      return TM_OFF;
    else if (below)   return TM_SUSPEND;
    else if (therm_n) return TM_IDLE;
    else              return TM_COUNT;
  endfunction

endpackage

// File: rtl/supply_cmp.sv
`timescale 1ns/1ps
module supply_cmp #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mon_en,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] low_limit,
  output logic                below_nxt,
  output logic                below_q
);

  function automatic logic is_under(logic [SAMPLE_W-1:0] s, logic [SAMPLE_W-1:0] l);
    return (s < l);
  endfunction

  logic take;
  assign take      = mon_en & smp_valid;
  assign below_nxt = take ? is_under(smp_data, low_limit) : below_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) below_q <= 1'b0;
    else        below_q <= below_nxt;
  end

  // R1: no fresh sample, no change of the comparison result
  p_stale_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && mon_en) |=> $stable(below_q));

endmodule

// File: rtl/thermal_timer.sv
`timescale 1ns/1ps
module thermal_timer
  import sslc_pkg::*;
#(
  parameter int TIMER_W  = 16,
  parameter int PRESCALE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tmr_mode_e          mode,
  output logic               tick,
  output logic [TIMER_W-1:0] timer_q
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0]      PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [TIMER_W-1:0] TMAX     = {TIMER_W{1'b1}};

  function automatic logic [TIMER_W-1:0] sat_inc(logic [TIMER_W-1:0] v);
    return (v == TMAX) ? v : v + 1'b1;
  endfunction

  logic          run;
  logic [PW-1:0] pre_q;

  assign run  = (mode == TM_COUNT);
  assign tick = run && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      timer_q <= '0;
    end else if (run) begin
      pre_q   <= tick ? '0 : pre_q + 1'b1;
      if (tick) timer_q <= sat_inc(timer_q);
    end
  end

  // R6: outside counting mode both the count and prescaler phase hold
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != TM_COUNT) |=> ($stable(timer_q) && $stable(pre_q)));

  // R7: saturation, never wrap
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_q == TMAX) |=> (timer_q == TMAX));

  // R5: the count only ever moves up by one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_q != $past(timer_q)) |-> (timer_q == $past(timer_q) + 1'b1));

endmodule

// File: rtl/status_alert.sv
`timescale 1ns/1ps
module status_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_now,
  input  logic rd_req,
  input  logic alert_en,
  output logic status_q,
  output logic alert
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   status_q <= 1'b0;
    else if (cond_now)            status_q <= 1'b1;
    else if (rd_req)              status_q <= 1'b0;
  end

  assign alert = status_q & alert_en;

  // R2: an under result is latched on the same edge
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond_now |=> status_q);

  // R3: the flag only drops after a read with the condition gone
  p_clear_needs_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q) |-> ($past(rd_req) && !$past(cond_now)));

endmodule

// File: rtl/supply_suspend_ctrl.sv
`timescale 1ns/1ps
module supply_suspend_ctrl
  import sslc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int TIMER_W  = 16,
  parameter int PRESCALE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mon_en,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] low_limit,
  input  logic                alert_en,
  input  logic                therm_n,
  input  logic                stat_rd,
  output logic                under_flag,
  output logic                alert,
  output logic [TIMER_W-1:0]  timer_val
);

  logic      below_nxt;
  logic      below_q;
  logic      tmr_tick;
  tmr_mode_e tmr_mode;

  supply_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .low_limit (low_limit),
    .below_nxt (below_nxt),
    .below_q   (below_q)
  );

  assign tmr_mode = pick_mode(mon_en, below_q, therm_n);

  thermal_timer #(.TIMER_W(TIMER_W), .PRESCALE(PRESCALE)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (tmr_mode),
    .tick    (tmr_tick),
    .timer_q (timer_val)
  );

  status_alert u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_now (below_nxt),
    .rd_req   (stat_rd),
    .alert_en (alert_en),
    .status_q (under_flag),
    .alert    (alert)
  );

  // R8: monitoring off keeps the timer and comparison frozen
  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> ($stable(timer_val) && $stable(below_q)));

  // R6: no tick may be produced while suspended
  p_no_tick_suspended_r6: assert property (@(posedge clk) disable iff (!rst_n)
    below_q |-> !tmr_tick);

  // R4: the alert never stands without the status bit
  p_alert_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> under_flag);

endmodule

// File: tb/sim_supply_suspend_ctrl.sv
`timescale 1ns/1ps
module sim_supply_suspend_ctrl;

  localparam int SW   = 4;
  localparam int TW   = 6;
  localparam int PR   = 3;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          mon_en = 1'b0, smp_valid = 1'b0, alert_en = 1'b0;
  logic          therm_n = 1'b1, stat_rd = 1'b0;
  logic [SW-1:0] smp_data = '0, low_limit = '0;
  logic          under_flag, alert;
  logic [TW-1:0] timer_val;

  supply_suspend_ctrl #(.SAMPLE_W(SW), .TIMER_W(TW), .PRESCALE(PR)) u0 (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .low_limit(low_limit), .alert_en(alert_en),
    .therm_n(therm_n), .stat_rd(stat_rd), .under_flag(under_flag),
    .alert(alert), .timer_val(timer_val)
  );

  int errs = 0, checks = 0;
  int act_cyc = 0;
  bit m_below = 0, m_flag = 0;
  int saved = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_timer();
    int v = act_cyc / PR;
    return (v > TMAX) ? TMAX : v;
  endfunction

  // One clock: update the reference from the inputs, then compare at negedge.
  task automatic tick();
    bit fresh_under;
    if (mon_en && !m_below && !therm_n) act_cyc++;
    fresh_under = (mon_en && smp_valid) ? (int'(smp_data) < int'(low_limit)) : m_below;
    if (fresh_under)  m_flag = 1;
    else if (stat_rd) m_flag = 0;
    m_below = fresh_under;
    @(posedge clk);
    @(negedge clk);
    chk(int'(timer_val) == exp_timer(), "R5", int'(timer_val), exp_timer());
    chk(under_flag == m_flag, "R3", int'(under_flag), int'(m_flag));
    chk(alert == (m_flag && alert_en), "R4", int'(alert), int'(m_flag && alert_en));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(timer_val == 0, "R8", int'(timer_val), 0);
    chk(under_flag == 0, "R8", int'(under_flag), 0);
    chk(alert == 0, "R8", int'(alert), 0);
    rst_n = 1'b1;

    // R8: monitoring off ignores a low sample and a thermal event
    therm_n = 0; smp_valid = 1; smp_data = 0; low_limit = 15; alert_en = 1;
    ticks(10);
    chk(under_flag == 0, "R8", int'(under_flag), 0);
    chk(timer_val == 0, "R8", int'(timer_val), 0);
    therm_n = 1; smp_valid = 0;

    // R1/R2: full sweep, read on every sample so the flag mirrors the result
    mon_en = 1;
    for (int l = 0; l < 16; l++) begin
      for (int s = 0; s < 16; s++) begin
        smp_data = SW'(s); low_limit = SW'(l); smp_valid = 1; stat_rd = 1;
        tick();
        chk(under_flag == (s < l), "R1", int'(under_flag), int'(s < l));
      end
    end
    smp_valid = 0; stat_rd = 0;

    // R3: sticky after recovery until read
    low_limit = 9; smp_data = 2; smp_valid = 1; tick();
    chk(under_flag == 1, "R2", int'(under_flag), 1);
    smp_data = 12; tick(); smp_valid = 0;
    chk(under_flag == 1, "R3", int'(under_flag), 1);
    stat_rd = 1; tick(); stat_rd = 0;
    chk(under_flag == 0, "R3", int'(under_flag), 0);

    // R3: read while still under keeps the flag; R1: stale data ignored
    smp_data = 1; smp_valid = 1; tick(); smp_valid = 0;
    stat_rd = 1; tick();
    chk(under_flag == 1, "R3", int'(under_flag), 1);
    smp_data = 14; tick();
    chk(under_flag == 1, "R1", int'(under_flag), 1);
    smp_valid = 1; tick(); smp_valid = 0; stat_rd = 0;
    chk(under_flag == 0, "R1", int'(under_flag), 0);

    // R4: alert follows enable combinationally
    smp_data = 0; smp_valid = 1; tick(); smp_valid = 0;
    alert_en = 0; #1;
    chk(alert == 0, "R4", int'(alert), 0);
    alert_en = 1; #1;
    chk(alert == 1, "R4", int'(alert), 1);
    smp_data = 10; smp_valid = 1; stat_rd = 1; tick();
    smp_valid = 0; stat_rd = 0;
    chk(alert == 0, "R4", int'(alert), 0);

    // R5: counting with gaps that keep the prescaler phase
    therm_n = 0; ticks(7);
    therm_n = 1; ticks(4);
    therm_n = 0; ticks(13);
    chk(int'(timer_val) == act_cyc / PR, "R5", int'(timer_val), act_cyc / PR);

    // R6: suspension freezes the count, recovery resumes it
    saved = int'(timer_val);
    smp_data = 3; smp_valid = 1; tick(); smp_valid = 0;
    saved = int'(timer_val);
    ticks(15);
    chk(int'(timer_val) == saved, "R6", int'(timer_val), saved);
    smp_data = 11; smp_valid = 1; tick(); smp_valid = 0;
    ticks(9);
    chk(int'(timer_val) > saved, "R6", int'(timer_val), saved + 3);

    // R8: disabling monitoring freezes too
    mon_en = 0; saved = int'(timer_val); ticks(8);
    chk(int'(timer_val) == saved, "R8", int'(timer_val), saved);
    mon_en = 1;

    // R7: saturation
    ticks(260);
    chk(int'(timer_val) == TMAX, "R7", int'(timer_val), TMAX);
    ticks(10);
    chk(int'(timer_val) == TMAX, "R7", int'(timer_val), TMAX);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule